// File: doc/BRIEF.md
# Programmable Frequency Output Generator

This block drives one output pin with a clock derived by integer division from one of two internal timebases. A fast and a slow timebase are produced on the single system clock as one-cycle enable pulses from a cascaded prescaler. A 4-bit code selects a divide ratio from 1 to 16 of the chosen timebase. The divided waveform can be inverted before it leaves the block. The block presents the pin as a tri-state pad model, with one signal for the data and one for the drive enable.

Software programs the block with a single 7-bit configuration write. The write carries the drive enable, the inversion, the timebase choice and the divisor code. A change of divisor or timebase waits until the running output period is complete, so a period in progress always keeps its full length. The pin stays undriven from reset until software sets the enable bit.

Top module: `freq_out_gen`

## Requirements
- R1: After a synchronous active-low reset, `pad_oe` is 0 (pin in high impedance) and `pad_dout` is 0. All configuration fields read as zero: enable off, no inversion, fast timebase, code 0.
- R2: `cfg_wdata` is captured only at a rising clock edge where `cfg_we` is 1. Its fields are: bit 0 drive enable, bit 1 invert, bit 2 timebase select (0 fast, 1 slow), bits 6:3 divisor code. With `cfg_we` at 0, changes on `cfg_wdata` have no effect on the pins.
- R3: The fast timebase pulses for one system cycle every `FAST_DIV` cycles. Its first pulse falls in cycle `FAST_DIV-1` after reset is released. The slow timebase pulses on every `SLOW_RATIO`-th fast pulse, starting with the `SLOW_RATIO`-th one.
- R4: An active code N gives an output period of N+1 pulses of the selected timebase. The divider state advances only on those pulses.
- R5: With code 0, the undelayed waveform is the selected timebase pulse itself.
- R6: With a ratio R of 2 or more, the waveform before inversion is high for the first floor(R/2) timebase periods of each output period and low for the rest.
- R7: A newly written code or timebase select becomes active only at the timebase pulse that ends the current output period, at the terminal count.
- R8: When the invert bit is 1, the pin data is the complement of the divided waveform.
- R9: The drive enable bit controls `pad_oe`. Setting it drives the pin and clearing it returns the pin to high impedance.
- R10: `pad_dout` and `pad_oe` are registered. Each shows, one cycle later, the waveform and configuration state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both timebases are enables on it |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word: {code[3:0], slow select, invert, drive enable} |
| pad_dout | output | 1 | Data to the tri-state pad |
| pad_oe | output | 1 | Drive enable to the tri-state pad; 0 means high impedance |

## Verification
A write sampled at rising edge k loads the configuration register at k. Inversion and enable therefore reach `pad_dout`/`pad_oe` at edge k+1. A new code or timebase waits for the next terminal-count pulse of the selected timebase, and its waveform appears on the pin one edge after that pulse. The bench keeps to this by pushing, at every rising edge, the pin value that the requirements predict for that edge. A scoreboard holds these values in a queue. A monitor pops each one at the following falling edge and compares it, so every comparison lands exactly one register stage after the state that produced it. Timebase pulse times come from the elapsed cycle count since reset, not from any counter in the design.

// File: rtl/freq_out_pkg.sv
// Shared types for the frequency output generator.
// Assumes a 7-bit configuration word whose packed layout matches cfg_word_t.
package freq_out_pkg;

    localparam int CODE_W = 4;
    localparam int CFG_W  = CODE_W + 3;

    // Timebase choice; value 0 selects the fast rate.
    typedef enum logic {
        TB_FAST = 1'b0,
        TB_SLOW = 1'b1
    } tb_sel_e;

    // Configuration word, MSB first: code, slow select, invert, drive enable.
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              slow_sel;
        logic              invert;
        logic              drive_en;
    } cfg_word_t;

endpackage

// File: rtl/fo_tick_gen.sv
// Timebase prescaler: makes two one-cycle enable pulses from the system clock.
// The fast pulse repeats every FAST_DIV cycles. The slow pulse repeats every
// SLOW_RATIO fast pulses and always coincides with a fast pulse.
// Assumes FAST_DIV >= 1 and SLOW_RATIO >= 1.
module fo_tick_gen #(
    parameter int FAST_DIV   = 25,
    parameter int SLOW_RATIO = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_tick,
    output logic slow_tick
);

    localparam int FW = (FAST_DIV   > 1) ? $clog2(FAST_DIV)   : 1;
    localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

    generate
        if (FAST_DIV == 1) begin : g_fast_every
            assign fast_tick = 1'b1;
        end else begin : g_fast_cnt
            logic [FW-1:0] fcnt;

            // Count system cycles modulo FAST_DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fcnt <= '0;
                else if (fcnt == FW'(FAST_DIV - 1))
                    fcnt <= '0;
                else
                    fcnt <= fcnt + 1'b1;
            end

            assign fast_tick = (fcnt == FW'(FAST_DIV - 1));

            // Fast pulses are never back to back when the divider exceeds one.
            p_fast_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
                fast_tick |=> !fast_tick);
        end

        if (SLOW_RATIO == 1) begin : g_slow_same
            assign slow_tick = fast_tick;
        end else begin : g_slow_cnt
            logic [SW-1:0] scnt;

            // Count fast pulses modulo SLOW_RATIO.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    scnt <= '0;
                else if (fast_tick) begin
                    if (scnt == SW'(SLOW_RATIO - 1))
                        scnt <= '0;
                    else
                        scnt <= scnt + 1'b1;
                end
            end

            assign slow_tick = fast_tick && (scnt == SW'(SLOW_RATIO - 1));
        end
    endgenerate

    // A slow pulse is always also a fast pulse.
    p_slow_in_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> fast_tick);

endmodule

// File: rtl/fo_ratio_div.sv
// Ratio divider: divides the selected timebase by code+1.
// Code and select are copied from the configuration only at terminal count,
// so the period in progress is never shortened. The output is combinational
// from registered state: the timebase pulse itself for code 0, otherwise
// high for floor(ratio/2) timebase periods and low for the remainder.
module fo_ratio_div
    import freq_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic [CODE_W-1:0] code_req,
    input  tb_sel_e           sel_req,
    output logic              wave
);

    logic [CODE_W-1:0] phase;
    logic [CODE_W-1:0] code_act;
    tb_sel_e           sel_act;
    logic              tick;
    logic              terminal;
    logic [CODE_W:0]   ratio;
    logic [CODE_W:0]   high_len;

    // Pick the active timebase pulse.
    always_comb begin
        tick = (sel_act == TB_SLOW) ? slow_tick : fast_tick;
    end

    assign terminal = tick && (phase == code_act);

    // Advance the phase on timebase pulses and load new settings at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            code_act <= '0;
            sel_act  <= TB_FAST;
        end else if (terminal) begin
            phase    <= '0;
            code_act <= code_req;
            sel_act  <= sel_req;
        end else if (tick) begin
            phase    <= phase + 1'b1;
        end
    end

    // Derive the undelayed waveform from the phase.
    always_comb begin
        ratio    = {1'b0, code_act} + 1'b1;
        high_len = ratio >> 1;
        if (code_act == '0)
            wave = tick;
        else
            wave = ({1'b0, phase} < high_len);
    end

    // The phase never passes the active terminal value.
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= code_act);

    // Without a timebase pulse the phase holds.
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));

    // The active code and select change only after a terminal pulse.
    p_defer_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (phase == code_act)) |=> ($stable(code_act) && $stable(sel_act)));

endmodule

// File: rtl/fo_pad_stage.sv
// Pad stage: applies inversion after the divider and registers both the data
// and the drive enable, so the pin cannot glitch when the divider changes.
// Assumes the inputs are synchronous to clk.
module fo_pad_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic wave,
    input  logic invert,
    input  logic drive_en,
    output logic pad_dout,
    output logic pad_oe
);

    // Register the polarity-adjusted level and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_dout <= 1'b0;
            pad_oe   <= 1'b0;
        end else begin
            pad_dout <= wave ^ invert;
            pad_oe   <= drive_en;
        end
    end

    // The pad only starts driving after the enable was set the cycle before.
    p_oe_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe) |-> $past(drive_en));

    // The pad only releases after the enable was cleared the cycle before.
    p_oe_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe) |-> !$past(drive_en));

endmodule

// File: rtl/freq_out_gen.sv
// Programmable frequency output generator, top level.
// Holds the configuration register and connects prescaler, divider and pad
// stage. A single clock domain: both timebases are enables on clk.
// Assumes cfg_we/cfg_wdata are synchronous to clk.
module freq_out_gen
    import freq_out_pkg::*;
#(
    parameter int FAST_DIV   = 25,
    parameter int SLOW_RATIO = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             pad_dout,
    output logic             pad_oe
);

    cfg_word_t cfg_q;
    logic      fast_tick;
    logic      slow_tick;
    logic      wave;

    // Capture the configuration word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_word_t'(cfg_wdata);
    end

    fo_tick_gen #(
        .FAST_DIV   (FAST_DIV),
        .SLOW_RATIO (SLOW_RATIO)
    ) u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick)
    );

    fo_ratio_div u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .code_req  (cfg_q.code),
        .sel_req   (tb_sel_e'(cfg_q.slow_sel)),
        .wave      (wave)
    );

    fo_pad_stage u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .wave     (wave),
        .invert   (cfg_q.invert),
        .drive_en (cfg_q.drive_en),
        .pad_dout (pad_dout),
        .pad_oe   (pad_oe)
    );

    // Coming out of reset the pin is undriven.
    p_reset_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pad_oe);

    // Without a write the configuration holds.
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: tb/tb_freq_out_gen.sv
// Scoreboard bench: a reference process pushes the pin values the
// requirements predict at each rising edge; a monitor pops and compares them
// at the next falling edge.
module tb_freq_out_gen;

    localparam int F = 3;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       pad_dout;
    logic       pad_oe;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R1";

    bit    q_d[$];
    bit    q_oe[$];
    string q_tag[$];

    // Reference state (requirement-level view)
    int cyc, m_cnt, a_code, a_sel, r_code, r_sel, r_pol, r_en;
    bit ftk, stk, tk, raw;

    always #2ns clk = ~clk;   // 250 MHz

    freq_out_gen #(.FAST_DIV(F), .SLOW_RATIO(S)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .pad_dout(pad_dout), .pad_oe(pad_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference: predict the pin value after each rising edge (R3..R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_cnt = 0; a_code = 0; a_sel = 0;
            r_code = 0; r_sel = 0; r_pol = 0; r_en = 0;
            q_d.delete(); q_oe.delete(); q_tag.delete();
        end else begin
            ftk = ((cyc % F) == F - 1);
            stk = ((cyc % (F * S)) == F * S - 1);
            tk  = a_sel ? stk : ftk;
            raw = (a_code == 0) ? tk : (m_cnt < (a_code + 1) / 2);
            q_d.push_back(raw ^ r_pol[0]);
            q_oe.push_back(r_en[0]);
            q_tag.push_back(cur_tag);
            if (tk) begin
                if (m_cnt == a_code) begin
                    m_cnt = 0; a_code = r_code; a_sel = r_sel;
                end else m_cnt++;
            end
            if (cfg_we) begin
                r_en = cfg_wdata[0]; r_pol = cfg_wdata[1];
                r_sel = cfg_wdata[2]; r_code = cfg_wdata[6:3];
            end
            cyc++;
        end
    end

    // Monitor: compare the pins against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && q_d.size() > 0) begin
            bit    ed, eo;
            string tg;
            ed = q_d.pop_front();
            eo = q_oe.pop_front();
            tg = q_tag.pop_front();
            check(pad_dout === ed, tg, "pad_dout", int'(pad_dout), int'(ed));
            check(pad_oe === eo, tg, "pad_oe", int'(pad_oe), int'(eo));
        end
    end

    task automatic wr(input int code, input bit slow, input bit inv,
                      input bit en, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        cfg_we    = 1'b1;
        cfg_wdata = {code[3:0], slow, inv, en};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state, pin undriven
        check(pad_oe === 1'b0, "R1", "reset pad_oe", int'(pad_oe), 0);
        check(pad_dout === 1'b0, "R1", "reset pad_dout", int'(pad_dout), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        run(20);
        // R5 and R3: code 0 passes fast pulses, enabled
        wr(0, 1'b0, 1'b0, 1'b1, "R5");
        run(30);
        // R9: enable just set; R4/R6 even ratio 4
        wr(3, 1'b0, 1'b0, 1'b1, "R6");
        run(60);
        // R6: odd ratio 5, written mid-period (R7 deferral)
        run(2);
        wr(4, 1'b0, 1'b0, 1'b1, "R7");
        run(80);
        // R4: largest ratio 16
        wr(15, 1'b0, 1'b0, 1'b1, "R4");
        run(160);
        // R8: inversion
        wr(15, 1'b0, 1'b1, 1'b1, "R8");
        run(60);
        // R3: slow timebase, ratio 2
        wr(1, 1'b1, 1'b0, 1'b1, "R3");
        run(150);
        // R5: code 0 on the slow timebase
        wr(0, 1'b1, 1'b0, 1'b1, "R5");
        run(80);
        // R7: back to fast, ratio 3, two writes before terminal
        wr(5, 1'b0, 1'b0, 1'b1, "R7");
        wr(2, 1'b0, 1'b1, 1'b1, "R7");
        run(80);
        // R2: data changes without strobe are ignored
        @(negedge clk);
        cur_tag = "R2";
        cfg_wdata = 7'b1111_010;
        run(60);
        // R10: single-cycle enable toggles seen one cycle later
        wr(2, 1'b0, 1'b1, 1'b0, "R10");
        wr(2, 1'b0, 1'b1, 1'b1, "R10");
        run(20);
        // R9: disable returns pin to high impedance
        wr(2, 1'b0, 1'b0, 1'b0, "R9");
        run(30);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule